// File: doc/BRIEF.md
# Interrupt Request Capture Latch

This block turns a set of interrupt request wires into a registered vector of pending requests. Each wire can be set as edge-sensitive or level-sensitive through a trigger-mode register. An edge-sensitive line latches a request on a rising input and keeps it until it is acknowledged. A level-sensitive line simply mirrors its input one clock later. Each line keeps a shadow of its last sampled level, so edges are found the same way in both modes and a change of mode causes no false edge.

The pending vector feeds a downstream priority resolver and a register read path; neither is part of this block. An acknowledge strobe with a line index comes back from the resolver when a request has been serviced. The acknowledge clears the indexed request only when that line is edge-sensitive. Request inputs must already be synchronous to `clk`. A build parameter fixes which trigger-mode bits are writable, and a line whose bit is not writable is built as a fixed edge-sensitive line with no mode flop.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low, `pending` and `trig_mode` are all zero, so every line is edge-sensitive (mode bit 0 = edge, 1 = level).
- R2: A cycle with `mode_we` high loads `trig_mode` with `mode_wdata & MODE_WMASK`, visible after that clock edge. With the default `MODE_WMASK` of 8'hFB, bit 2 always reads 0 and line 2 always acts as edge-sensitive.
- R3: For a level-sensitive line, `pending[i]` equals the value `req_in[i]` had at the previous clock edge, both when the input rises and when it falls.
- R4: For an edge-sensitive line, `pending[i]` is set after an edge where `req_in[i]` is high and was low at the edge before. An input that stays high sets it only once.
- R5: For an edge-sensitive line, a falling input does not clear a pending request.
- R6: An acknowledge (`ack_valid` high, line `ack_idx`) clears `pending[ack_idx]` of an edge-sensitive line at that edge and leaves every other line unchanged.
- R7: An acknowledge of a level-sensitive line has no effect: its `pending` bit keeps following the input.
- R8: If a rising edge and an acknowledge hit the same edge-sensitive line at the same clock edge, the request stays set.
- R9: The last-level shadow resets to low, so a line already high when reset is released counts as a rising edge at the first edge after release.
- R10: A line switched from level to edge mode while its input is high keeps its request until it is acknowledged. After the acknowledge it is not set again while the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_LINES | Synchronous interrupt request levels |
| mode_we | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | NUM_LINES | Trigger-mode write value (1 = level) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged line |
| pending | output | NUM_LINES | Latched request vector |
| trig_mode | output | NUM_LINES | Current trigger-mode register |

## Verification
A corrupted shadow bit shows as a request that appears one cycle after an acknowledge while the input is still high, or as a missed rising edge. Either one is visible on `pending` at the next clock edge. A wrong mode bit shows up within one or two cycles: a falling input clears a latched request, or an acknowledge fails to clear an edge request. The checker compares `pending` every cycle against a shadow of `req_in` that it keeps itself, so the first such divergence is flagged on the same edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // Next state of one request bit. A fresh edge takes precedence over an
   // acknowledge that lands on the same clock edge.
   function automatic logic next_req(trig_e mode, logic cur, logic lvl,
                                     logic last_lvl, logic ack_hit);
      logic rise;
      rise = lvl & ~last_lvl;
      if (mode == TRIG_LEVEL) return lvl;
      if (rise) return 1'b1;
      if (ack_hit) return 1'b0;
      return cur;
   endfunction

endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
   parameter int unsigned   NUM_LINES = 8,
   parameter logic [NUM_LINES-1:0] WMASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_LINES-1:0] wr_data,
   output logic [NUM_LINES-1:0] mode_q
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
      if (WMASK[i]) begin : g_rw
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (wr_en) bit_q <= wr_data[i];
         end
         assign mode_q[i] = bit_q;
      end else begin : g_fixed
         assign mode_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                 ack_valid,
   input  logic [IDX_W-1:0]     ack_idx,
   output logic [NUM_LINES-1:0] ack_vec
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
      assign ack_vec[i] = ack_valid && (ack_idx == IDX_W'(i));
   end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_latch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic level_mode,
   input  logic lvl_in,
   input  logic ack_hit,
   output logic req_q
);
   logic  last_q;
   trig_e mode;

   assign mode = level_mode ? TRIG_LEVEL : TRIG_EDGE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         last_q <= 1'b0;
      end else begin
         req_q  <= next_req(mode, req_q, lvl_in, last_q, ack_hit);
         last_q <= lvl_in;
      end
   end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned NUM_LINES  = 8,
   parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hFB,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_in,
   input  logic                 mode_we,
   input  logic [NUM_LINES-1:0] mode_wdata,
   input  logic                 ack_valid,
   input  logic [IDX_W-1:0]     ack_idx,
   output logic [NUM_LINES-1:0] pending,
   output logic [NUM_LINES-1:0] trig_mode
);
   if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
      $error("irq_req_latch: NUM_LINES must be 1..64");
   end

   logic [NUM_LINES-1:0] ack_vec;

   irq_mode_reg #(.NUM_LINES(NUM_LINES), .WMASK(MODE_WMASK)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(mode_we), .wr_data(mode_wdata),
      .mode_q(trig_mode)
   );

   irq_ack_dec #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ack (
      .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_vec(ack_vec)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_cell u_cell (
         .clk(clk), .rst_n(rst_n), .level_mode(trig_mode[i]),
         .lvl_in(req_in[i]), .ack_hit(ack_vec[i]), .req_q(pending[i])
      );
   end
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
   parameter int unsigned NUM_LINES  = 8,
   parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hFB,
   parameter int unsigned IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] req_in,
   input logic                 mode_we,
   input logic [NUM_LINES-1:0] mode_wdata,
   input logic                 ack_valid,
   input logic [IDX_W-1:0]     ack_idx,
   input logic [NUM_LINES-1:0] pending,
   input logic [NUM_LINES-1:0] trig_mode
);
   logic [NUM_LINES-1:0] prev_in, ackv, rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_in <= '0;
      else        prev_in <= req_in;
   end

   always_comb begin
      ackv = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (ack_valid && ack_idx == IDX_W'(i)) ackv[i] = 1'b1;
   end
   assign rise = req_in & ~prev_in;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pending == '0 && trig_mode == '0));

   assert_mode_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode & ~MODE_WMASK) == '0);

   assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> trig_mode == ($past(mode_wdata) & MODE_WMASK));

   assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending ^ $past(req_in)) & $past(trig_mode)) == '0);

   assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise) & ~$past(trig_mode)) & ~pending) == '0);

   assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pending) & ~$past(trig_mode) & ~$past(ackv)) & ~pending) == '0);

   assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(ackv) & ~$past(trig_mode) & ~$past(rise)) & pending) == '0);
endmodule

bind irq_req_latch irq_req_latch_chk #(
   .NUM_LINES(NUM_LINES), .MODE_WMASK(MODE_WMASK), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_in(req_in), .mode_we(mode_we),
   .mode_wdata(mode_wdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
   .pending(pending), .trig_mode(trig_mode)
);

// File: tb/irq_req_latch_test.sv
module irq_req_latch_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0;
   logic       mode_we = 1'b0;
   logic [7:0] mode_wdata = '0;
   logic       ack_valid = 1'b0;
   logic [2:0] ack_idx = '0;
   logic [7:0] pending, trig_mode;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_req_latch uut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .mode_we(mode_we),
      .mode_wdata(mode_wdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
      .pending(pending), .trig_mode(trig_mode)
   );

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_in = '0; mode_we = 0; ack_valid = 0;
      step(); rst_n = 1'b1; step();
   endtask

   task automatic write_mode(logic [7:0] v);
      mode_we = 1'b1; mode_wdata = v; step(); mode_we = 1'b0;
   endtask

   task automatic ack(logic [2:0] i);
      ack_valid = 1'b1; ack_idx = i; step(); ack_valid = 1'b0;
   endtask

   task automatic t_reset_edge();
      rst_n = 1'b0; req_in = 8'h01; step();
      check("R1 pending in reset", pending, 8'h00);
      check("R1 mode in reset", trig_mode, 8'h00);
      rst_n = 1'b1; step();
      check("R9 high at release latched", pending, 8'h01);
      ack(3'd0);
      check("R6 ack clears edge", pending, 8'h00);
      step();
      check("R4 held high no re-set", pending, 8'h00);
   endtask

   task automatic t_mode_mask();
      do_reset();
      write_mode(8'hFF);
      check("R2 masked write", trig_mode, 8'hFB);
      req_in = 8'h04; step();
      check("R2 line2 fixed edge set", pending, 8'h04);
      ack(3'd2);
      check("R2 line2 ack clears", pending, 8'h00);
      write_mode(8'h00);
      check("R2 write zero", trig_mode, 8'h00);
   endtask

   task automatic t_level();
      do_reset();
      write_mode(8'h02);
      req_in = 8'h02; step();
      check("R3 level rise", pending, 8'h02);
      req_in = 8'h00; step();
      check("R3 level fall", pending, 8'h00);
      req_in = 8'h02; step();
      ack(3'd1);
      check("R7 ack on level ignored", pending, 8'h02);
   endtask

   task automatic t_edge();
      do_reset();
      req_in = 8'h10; step();
      check("R4 rising sets", pending, 8'h10);
      req_in = 8'h00; step(); step();
      check("R5 fall keeps request", pending, 8'h10);
      req_in = 8'h20; step();
      check("R4 second line", pending, 8'h30);
      ack(3'd5);
      check("R6 ack only indexed line", pending, 8'h10);
      ack(3'd4);
      check("R6 ack clears last", pending, 8'h00);
   endtask

   task automatic t_collision();
      do_reset();
      req_in = 8'h08; step(); req_in = 8'h00; step();
      req_in = 8'h08; ack(3'd3);
      check("R8 edge wins over ack", pending, 8'h08);
   endtask

   task automatic t_switch();
      do_reset();
      write_mode(8'h40);
      req_in = 8'h40; step();
      write_mode(8'h00);
      step();
      check("R10 kept after switch", pending, 8'h40);
      ack(3'd6);
      check("R10 ack clears", pending, 8'h00);
      step();
      check("R10 no false edge", pending, 8'h00);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #5;
      t_reset_edge();
      t_mode_mask();
      t_level();
      t_edge();
      t_collision();
      t_switch();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule